// File: doc/BRIEF.md
# Quadrature Encoder Counter

This block turns the two phase signals of an incremental rotary or linear encoder into a position count. Each raw input first crosses into the block's clock domain through a short synchronizer. It then passes a glitch filter that only accepts a new level once that level has held for a set number of cycles. A decoder compares the filtered pair with its value from the previous cycle and classifies the step as forward, backward, no move or invalid.

The count advances by one on every accepted edge of either phase, which gives four counts per full encoder cycle. It wraps inside the range from zero to a programmable reload value. The block also reports the direction of the latest counted step. It pulses one of two event outputs when that direction reverses: one event for a turn to up-counting and one for a turn to down-counting.

Counting only happens while the block is enabled and set to continuous operation. While either control is low, the count holds. The filters keep tracking the inputs during that time, so edges that occur while idle are never replayed.

Top module: `qenc_counter`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), count is 0, dir_down is 0 and both event outputs are 0.
- R2: Taking the filtered pair as {in_a,in_b}, the sequence 00, 10, 11, 01, 00 adds one per step and the reverse sequence subtracts one per step, so a full phase cycle moves the count by four.
- R3: An up step taken while count is greater than or equal to reload sets count to 0.
- R4: A down step taken while count is 0 sets count to reload.
- R5: While enable or continuous is 0, count, dir_down and both event outputs hold or stay low, and input transitions seen in that time are not counted later.
- R6: A level on an input that lasts fewer than FILT_LEN cycles after synchronization is not counted.
- R7: A step in which both filtered inputs change in the same cycle changes neither the count nor the direction, and raises no event.
- R8: dir_down is 1 when the last counted step was a down step and 0 when it was an up step.
- R9: up_evt (or down_evt) is a one-cycle pulse in the same cycle as a counted up (or down) step whose direction differs from the previous counted step; the two never pulse together.
- R10: The first counted step after counting becomes active, whether after reset or after a pause, raises no event.
- R11: A clean edge on an input changes count exactly SYNC_STAGES + FILT_LEN + 1 clock edges after the first edge that samples it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Counting enable |
| continuous | input | 1 | Continuous-mode select; counting requires it high |
| in_a | input | 1 | Raw phase A input, asynchronous |
| in_b | input | 1 | Raw phase B input, asynchronous |
| reload | input | CNT_W | Upper limit of the count range |
| count | output | CNT_W | Current position count |
| dir_down | output | 1 | 1 when the last counted step was downward |
| up_evt | output | 1 | Pulse on a reversal to up-counting |
| down_evt | output | 1 | Pulse on a reversal to down-counting |

## Verification
The bench builds the block with CNT_W = 16, SYNC_STAGES = 2 and FILT_LEN = 3. It drives a reload of 5, which brings both wrap directions within a few encoder steps. The short filter lets a two-cycle pulse act as a glitch and gives a six-edge latency that can be checked cycle by cycle. Later the reload is lowered below the current count, which exercises the greater-than-reload wrap rule.

// File: rtl/qenc_pkg.sv
// Shared types for the quadrature encoder counter.
// Assumes nothing beyond standard SystemVerilog packages.
package qenc_pkg;

    // Classification of one filtered sample step.
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2,
        STEP_BAD  = 2'd3
    } step_t;

endpackage

// File: rtl/qenc_filter.sv
// Synchronizer plus level-persistence glitch filter for one raw input.
// The output takes a new level only after the synchronized input has
// differed from it for FILT_LEN consecutive cycles.
// Assumes SYNC_STAGES >= 2 and FILT_LEN >= 2.
module qenc_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int FCW = $clog2(FILT_LEN);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [FCW-1:0]         run_len;
    logic                   sync_out;

    assign sync_out = sync_q[SYNC_STAGES-1];

    // Shift the raw level through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
    end

    // Count how long the synchronized level has differed, then accept it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_len <= '0;
            clean   <= 1'b0;
        end else if (sync_out == clean) begin
            run_len <= '0;
        end else if (run_len == FCW'(FILT_LEN - 1)) begin
            clean   <= sync_out;
            run_len <= '0;
        end else begin
            run_len <= run_len + 1'b1;
        end
    end

    // The filtered level only moves toward a differing synchronized level.
    assert_filter_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean) |-> $past(sync_out != clean));

endmodule

// File: rtl/qenc_decode.sv
// Step decoder: compares the filtered phase pair with its previous value
// and reports up, down, no move or invalid (both phases changed).
// Assumes inputs are already synchronized and filtered.
module qenc_decode
    import qenc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] ab,      // bit 1 = phase A, bit 0 = phase B
    output step_t      step
);
    logic [1:0] prev_ab;
    logic [1:0] cur_ph;
    logic [1:0] prev_ph;
    logic [1:0] ph_diff;

    // Remember last cycle's filtered pair.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_ab <= 2'b00;
        else        prev_ab <= ab;
    end

    // Map the Gray-coded pair to a phase index 0..3 and take the difference.
    always_comb begin
        cur_ph  = {ab[0], ab[1] ^ ab[0]};
        prev_ph = {prev_ab[0], prev_ab[1] ^ prev_ab[0]};
        ph_diff = cur_ph - prev_ph;
        unique case (ph_diff)
            2'd0:    step = STEP_NONE;
            2'd1:    step = STEP_UP;
            2'd3:    step = STEP_DOWN;
            default: step = STEP_BAD;
        endcase
    end

    // A single-phase change always yields a valid direction.
    assert_single_change_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(ab ^ prev_ab) == 1) |-> (step == STEP_UP || step == STEP_DOWN));

endmodule

// File: rtl/qenc_counter.sv
// Quadrature encoder counter: filters two phase inputs, decodes steps at
// four counts per cycle, and keeps a wrapping count in 0..reload with a
// direction output and reversal events.
// Assumes in_a/in_b are asynchronous; reload may change at any time.
module qenc_counter
    import qenc_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             continuous,
    input  logic             in_a,
    input  logic             in_b,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count,
    output logic             dir_down,
    output logic             up_evt,
    output logic             down_evt
);
    logic [1:0]       raw_ab;
    logic [1:0]       clean_ab;
    step_t            step;
    logic             run;
    logic             has_dir;
    logic             is_move;
    logic             go_down;
    logic [CNT_W-1:0] next_count;

    assign raw_ab = {in_a, in_b};
    assign run    = enable & continuous;

    // One filter per phase input.
    for (genvar g = 0; g < 2; g++) begin : g_filt
        qenc_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .FILT_LEN   (FILT_LEN)
        ) u_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw_ab[g]),
            .clean(clean_ab[g])
        );
    end

    qenc_decode u_dec (
        .clk  (clk),
        .rst_n(rst_n),
        .ab   (clean_ab),
        .step (step)
    );

    // Next count with wrap at both ends of the range.
    always_comb begin
        is_move = (step == STEP_UP) || (step == STEP_DOWN);
        go_down = (step == STEP_DOWN);
        if (go_down) next_count = (count == '0) ? reload : count - 1'b1;
        else         next_count = (count >= reload) ? '0 : count + 1'b1;
    end

    // Update count, direction and reversal events on each counted step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count    <= '0;
            dir_down <= 1'b0;
            has_dir  <= 1'b0;
            up_evt   <= 1'b0;
            down_evt <= 1'b0;
        end else begin
            up_evt   <= 1'b0;
            down_evt <= 1'b0;
            if (!run) begin
                has_dir <= 1'b0;
            end else if (is_move) begin
                count    <= next_count;
                dir_down <= go_down;
                has_dir  <= 1'b1;
                if (has_dir && (dir_down != go_down)) begin
                    up_evt   <= !go_down;
                    down_evt <= go_down;
                end
            end
        end
    end

    // Idle block holds its count.
    assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(count));

    // Invalid steps leave the count alone.
    assert_bad_step_noop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step == STEP_BAD) |=> $stable(count) && !up_evt && !down_evt);

    // Events are exclusive and agree with the reported direction.
    assert_evt_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({up_evt, down_evt}) <= 1);
    assert_evt_matches_dir_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (up_evt |-> !dir_down) and (down_evt |-> dir_down));

    // No event on the first step once counting starts.
    assert_first_step_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |=> !up_evt && !down_evt);

endmodule

// File: tb/sim_qenc_counter.sv
// Bench for qenc_counter: behavioural reference model compared every cycle
// plus directed end-state checks with hand-computed values.
module sim_qenc_counter;
    localparam int W    = 16;
    localparam int SY   = 2;
    localparam int FL   = 3;
    localparam int HOLD = 10;

    logic         clk = 1'b0;
    logic         rst_n, enable, continuous, in_a, in_b;
    logic [W-1:0] reload;
    logic [W-1:0] count;
    logic         dir_down, up_evt, down_evt;

    int n_tests = 0;
    int n_fail  = 0;
    int n_up    = 0;
    int n_dn    = 0;
    bit cmp_on  = 1'b0;
    bit done    = 1'b0;
    int ph      = 0;

    always #10 clk = ~clk;   // 50 MHz

    qenc_counter #(.CNT_W(W), .SYNC_STAGES(SY), .FILT_LEN(FL)) u0 (
        .clk(clk), .rst_n(rst_n), .enable(enable), .continuous(continuous),
        .in_a(in_a), .in_b(in_b), .reload(reload), .count(count),
        .dir_down(dir_down), .up_evt(up_evt), .down_evt(down_evt)
    );

    // ---------------- reference model ----------------
    logic [1:0] m_pipe[$];
    int         m_len[2];
    logic [1:0] m_clean, m_prev;
    int         m_count;
    bit         m_dir, m_has, m_up, m_dn;

    function automatic int phase_of(logic [1:0] v);
        case (v)
            2'b00:   return 0;
            2'b10:   return 1;
            2'b11:   return 2;
            default: return 3;
        endcase
    endfunction

    always @(posedge clk) begin : model
        int d;
        logic [1:0] synced;
        if (!rst_n) begin
            m_pipe = {};
            for (int i = 0; i < SY; i++) m_pipe.push_back(2'b00);
            m_len[0] = 0; m_len[1] = 0;
            m_clean = 2'b00; m_prev = 2'b00;
            m_count = 0; m_dir = 0; m_has = 0; m_up = 0; m_dn = 0;
        end else begin
            d = (phase_of(m_clean) - phase_of(m_prev) + 4) % 4;
            m_up = 0; m_dn = 0;
            if (!(enable && continuous)) begin
                m_has = 0;
            end else if (d == 1 || d == 3) begin
                if (d == 1) m_count = (m_count >= int'(reload)) ? 0 : m_count + 1;
                else        m_count = (m_count == 0) ? int'(reload) : m_count - 1;
                if (m_has && (m_dir != (d == 3))) begin
                    m_up = (d == 1);
                    m_dn = (d == 3);
                end
                m_dir = (d == 3);
                m_has = 1;
            end
            m_prev = m_clean;
            synced = m_pipe[0];
            for (int k = 0; k < 2; k++) begin
                if (synced[k] == m_clean[k]) m_len[k] = 0;
                else if (m_len[k] == FL - 1) begin
                    m_clean[k] = synced[k];
                    m_len[k] = 0;
                end else m_len[k]++;
            end
            m_pipe.push_back({in_a, in_b});
            void'(m_pipe.pop_front());
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Per-cycle comparison against the model and event tally.
    always @(negedge clk) begin
        if (cmp_on && !done) begin
            check(int'(count) == m_count, "R2/R3/R4 count vs model", int'(count), m_count);
            check(dir_down == m_dir, "R8 dir vs model", dir_down, m_dir);
            check(up_evt == m_up, "R9 up_evt vs model", up_evt, m_up);
            check(down_evt == m_dn, "R9 down_evt vs model", down_evt, m_dn);
            if (up_evt)   n_up++;
            if (down_evt) n_dn++;
        end
    end

    function automatic logic [1:0] enc(int p);
        case (p & 3)
            0:       return 2'b00;
            1:       return 2'b10;
            2:       return 2'b11;
            default: return 2'b01;
        endcase
    endfunction

    task automatic move(input int delta);
        ph = (ph + delta) & 3;
        {in_a, in_b} = enc(ph);
        repeat (HOLD) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 20);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; enable = 0; continuous = 0; in_a = 0; in_b = 0; reload = W'(5);
        repeat (3) @(negedge clk);
        cmp_on = 1'b1;
        check(count == 0, "R1 reset count", count, 0);
        check(dir_down == 0 && up_evt == 0 && down_evt == 0, "R1 reset dir/flags",
              {dir_down, up_evt, down_evt}, 0);
        rst_n = 1;
        enable = 1; continuous = 1;
        @(negedge clk);

        repeat (4) move(1);
        check(count == 4, "R2 four up steps", count, 4);
        check(n_up == 0 && n_dn == 0, "R10 no event on first steps", n_up + n_dn, 0);

        repeat (2) move(1);
        check(count == 0, "R3 wrap up past reload", count, 0);

        move(-1);
        check(count == 5, "R4 wrap down to reload", count, 5);
        check(n_dn == 1, "R9 down reversal event", n_dn, 1);
        check(dir_down == 1, "R8 direction down", dir_down, 1);

        in_a = ~in_a; repeat (2) @(negedge clk); in_a = ~in_a;
        repeat (HOLD) @(negedge clk);
        check(count == 5, "R6 glitch ignored", count, 5);

        move(2);
        check(count == 5, "R7 double change ignored", count, 5);
        check(dir_down == 1 && n_up == 0, "R7 no dir change/event", n_up, 0);

        enable = 0;
        repeat (2) move(1);
        check(count == 5, "R5 disabled holds", count, 5);
        enable = 1; continuous = 0;
        move(1);
        check(count == 5, "R5 non-continuous holds", count, 5);
        continuous = 1;
        repeat (HOLD) @(negedge clk);
        check(count == 5, "R5 idle edges not replayed", count, 5);

        move(1);
        check(count == 0, "R10 first step after resume counts", count, 0);
        check(n_up == 0, "R10 no event after resume", n_up, 0);
        check(dir_down == 0, "R8 direction up", dir_down, 0);

        move(-1);
        check(count == 5 && n_dn == 2, "R9 second down reversal", n_dn, 2);
        move(-1);
        check(count == 4 && n_dn == 2, "R9 no event same direction", count, 4);
        move(1);
        check(count == 5 && n_up == 1, "R9 up reversal event", n_up, 1);

        reload = W'(2);
        move(1);
        check(count == 0, "R3 wrap from above reload", count, 0);
        move(-1);
        check(count == 2, "R4 wrap to new reload", count, 2);

        // Latency: 2 sync + 3 filter + 1 count edges.
        ph = (ph + 1) & 3;
        {in_a, in_b} = enc(ph);
        repeat (SY + FL) @(negedge clk);
        check(count == 2, "R11 not yet counted", count, 2);
        @(negedge clk);
        check(count == 0, "R11 counted at expected edge", count, 0);
        repeat (HOLD) @(negedge clk);

        finish_run();
    end
endmodule